// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Receiver

This block terminates the three-line programming port of a frequency synthesizer. A host drives serial data, a serial clock and a load strobe. The block brings all three lines into the system clock domain, and each serial clock rising edge shifts one bit into a 24-bit word while the load line is low, most significant bit first. When the load line rises, the two least significant bits of the word pick one of four holding latches: reference divider, feedback (N) divider, function, or initialization. The whole word is copied into that latch.

The held latches are decoded into the fields the synthesizer core consumes:
- the reference division ratio, the anti-backlash width, the test bits and the lock precision;
- the A and B counter values and the charge-pump gain;
- the prescaler select, the two power-down controls, the phase detector polarity, the monitor output select and the counter reset.

A write to the initialization latch loads the function latch as well and gives the counter reset a one-cycle kick. A ready flag tells the core when the configuration is complete. After that, the host can retune by rewriting the N latch alone.

Top module: `synth_prog_rx`

## Requirements
- R1: On each synchronized rising edge of `ser_clk` while `ser_le` is low, the 24-bit shift word moves left by one and takes `ser_data` as its new bit 0, so the first bit sent ends in bit 23. `ser_clk` edges while `ser_le` is high leave the shift word unchanged.
- R2: On a synchronized rising edge of `ser_le`, the shift word is copied into one latch, chosen by word bits 1:0 (00 reference, 01 N, 10 function, 11 initialization). All other latches keep their contents.
- R3: The reference latch drives `ref_div` from bits 15:2, `bl_width` from bits 17:16, `test_mode` from bits 19:18 and `lock_prec` from bit 20.
- R4: The N latch drives `a_count` from bits 7:2, `b_count` from bits 20:8 and `cp_gain` from bit 21.
- R5: The function latch drives `ctr_reset` (level) from bit 2, `pwr_dn1` from bit 3, `mux_sel` from bits 6:4, `pd_polarity` from bit 7, `pwr_dn2` from bit 21 and `presc_sel` from bits 23:22.
- R6: An initialization write also loads the function latch with the same word, and raises `ctr_reset` for exactly one clock cycle on top of the level from bit 2. A plain function write gives no such pulse.
- R7: A load strobe that follows fewer than 24 serial clocks still latches the current shift word. That word is the earlier contents shifted left by the number of bits actually received.
- R8: `cfg_ready` is low after reset. It goes high once the reference, N and function latches have each been written; an initialization write counts as a function write. It then stays high until the next reset.
- R9: During reset and right after it, every decoded field output is zero, and so is the shift word.
- R10: Once `cfg_ready` is high, an N-latch write changes only `a_count`, `b_count` and `cp_gain`. All other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial programming clock (asynchronous) |
| ser_data | input | 1 | Serial programming data (asynchronous) |
| ser_le | input | 1 | Load strobe, word transferred on rising edge (asynchronous) |
| ref_div | output | 14 | Reference division ratio |
| bl_width | output | 2 | Anti-backlash pulse width select |
| test_mode | output | 2 | Test bits |
| lock_prec | output | 1 | Lock detect precision |
| a_count | output | 6 | A counter value |
| b_count | output | 13 | B counter value |
| cp_gain | output | 1 | Charge-pump gain select |
| presc_sel | output | 2 | Prescaler select |
| pwr_dn1 | output | 1 | Power-down control 1 |
| pwr_dn2 | output | 1 | Power-down control 2 |
| pd_polarity | output | 1 | Phase detector polarity |
| mux_sel | output | 3 | Monitor output select |
| ctr_reset | output | 1 | Counter reset (latched level, plus one-cycle pulse on init write) |
| cfg_ready | output | 1 | All required latches written since reset |

## Verification
The bench builds the block with the default two-stage synchronizers and a 24-bit word. Each serial level is held for four system clocks, so every edge passes through the synchronizer and edge detector cleanly. These values give access to the following cases:
- a full write to every latch, including the initialization copy into the function latch and its single reset pulse;
- the ready flag rising only after the third distinct latch type is written;
- clock edges sent while the load line is high;
- a short word made of only six bits;
- a retune by an N-only write;
- a reset in mid-run.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 24;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_REF  = 2'd0,
    SEL_NDIV = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_INIT = 2'd3
  } latch_sel_e;

  typedef logic [WORD_W-1:0] word_t;

  function automatic latch_sel_e word_sel(input word_t w);
    return latch_sel_e'(w[SEL_W-1:0]);
  endfunction

  // reference latch fields
  function automatic logic [13:0] fld_ref_div(input word_t w);
    return w[15:2];
  endfunction
  function automatic logic [1:0] fld_bl_width(input word_t w);
    return w[17:16];
  endfunction
  function automatic logic [1:0] fld_test(input word_t w);
    return w[19:18];
  endfunction
  function automatic logic fld_lock_prec(input word_t w);
    return w[20];
  endfunction

  // N latch fields
  function automatic logic [5:0] fld_a(input word_t w);
    return w[7:2];
  endfunction
  function automatic logic [12:0] fld_b(input word_t w);
    return w[20:8];
  endfunction
  function automatic logic fld_cp_gain(input word_t w);
    return w[21];
  endfunction

  // function / initialization latch fields
  function automatic logic fld_ctr_rst(input word_t w);
    return w[2];
  endfunction
  function automatic logic fld_pd1(input word_t w);
    return w[3];
  endfunction
  function automatic logic [2:0] fld_mux(input word_t w);
    return w[6:4];
  endfunction
  function automatic logic fld_pol(input word_t w);
    return w[7];
  endfunction
  function automatic logic fld_pd2(input word_t w);
    return w[21];
  endfunction
  function automatic logic [1:0] fld_presc(input word_t w);
    return w[23:22];
  endfunction
endpackage

// File: rtl/synth_sync.sv
module synth_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/synth_shifter.sv
module synth_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/synth_latch_bank.sv
module synth_latch_bank
  import synth_prog_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t word,
  output word_t r_word,
  output word_t n_word,
  output word_t f_word,
  output logic [3:0] wr_stb,
  output logic  init_pulse,
  output logic  ready
);
  latch_sel_e sel;
  logic [2:0] seen;

  assign sel = word_sel(word);

  always_comb begin
    wr_stb = '0;
    for (int i = 0; i < 4; i++) begin
      if (load && (sel == latch_sel_e'(i))) wr_stb[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_word     <= '0;
      n_word     <= '0;
      f_word     <= '0;
      init_pulse <= 1'b0;
      seen       <= '0;
    end else begin
      init_pulse <= wr_stb[SEL_INIT];
      if (wr_stb[SEL_REF]) begin
        r_word  <= word;
        seen[0] <= 1'b1;
      end
      if (wr_stb[SEL_NDIV]) begin
        n_word  <= word;
        seen[1] <= 1'b1;
      end
      if (wr_stb[SEL_FUNC] || wr_stb[SEL_INIT]) begin
        f_word  <= word;
        seen[2] <= 1'b1;
      end
    end
  end

  assign ready = &seen;
endmodule

// File: rtl/synth_prog_rx.sv
module synth_prog_rx
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [13:0] ref_div,
  output logic [1:0]  bl_width,
  output logic [1:0]  test_mode,
  output logic        lock_prec,
  output logic [5:0]  a_count,
  output logic [12:0] b_count,
  output logic        cp_gain,
  output logic [1:0]  presc_sel,
  output logic        pwr_dn1,
  output logic        pwr_dn2,
  output logic        pd_polarity,
  output logic [2:0]  mux_sel,
  output logic        ctr_reset,
  output logic        cfg_ready
);
  localparam int LINES = 3;

  logic [LINES-1:0] line_s;
  logic             sclk_s, data_s, le_s;
  logic             sclk_d, le_d;
  logic             sclk_rise, le_rise, shift_en;
  word_t            shift_word, r_word, n_word, f_word;
  logic [3:0]       wr_stb;
  logic             init_pulse;

  synth_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_le, ser_data, ser_clk}),
    .q     (line_s)
  );

  assign sclk_s = line_s[0];
  assign data_s = line_s[1];
  assign le_s   = line_s[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      le_d   <= le_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign le_rise   = le_s & ~le_d;
  assign shift_en  = sclk_rise & ~le_s;

  synth_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (data_s),
    .word     (shift_word)
  );

  synth_latch_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (le_rise),
    .word       (shift_word),
    .r_word     (r_word),
    .n_word     (n_word),
    .f_word     (f_word),
    .wr_stb     (wr_stb),
    .init_pulse (init_pulse),
    .ready      (cfg_ready)
  );

  assign ref_div     = fld_ref_div(r_word);
  assign bl_width    = fld_bl_width(r_word);
  assign test_mode   = fld_test(r_word);
  assign lock_prec   = fld_lock_prec(r_word);
  assign a_count     = fld_a(n_word);
  assign b_count     = fld_b(n_word);
  assign cp_gain     = fld_cp_gain(n_word);
  assign presc_sel   = fld_presc(f_word);
  assign pwr_dn1     = fld_pd1(f_word);
  assign pwr_dn2     = fld_pd2(f_word);
  assign pd_polarity = fld_pol(f_word);
  assign mux_sel     = fld_mux(f_word);
  assign ctr_reset   = fld_ctr_rst(f_word) | init_pulse;
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        le_s,
  input logic        sclk_rise,
  input logic        le_rise,
  input logic [3:0]  wr_stb,
  input logic        init_pulse,
  input logic [23:0] shift_word,
  input logic [23:0] n_word,
  input logic [23:0] f_word,
  input logic        cfg_ready
);
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && sclk_rise) |=> $stable(shift_word));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R2
  n_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(n_word));

  // R6
  init_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[3] |=> (f_word == $past(shift_word)));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> !init_pulse);

  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);
endmodule

bind synth_prog_rx synth_prog_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .le_s       (le_s),
  .sclk_rise  (sclk_rise),
  .le_rise    (le_rise),
  .wr_stb     (wr_stb),
  .init_pulse (init_pulse),
  .shift_word (shift_word),
  .n_word     (n_word),
  .f_word     (f_word),
  .cfg_ready  (cfg_ready)
);

// File: tb/synth_prog_rx_test.sv
module synth_prog_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_div;
  logic [1:0]  bl_width, test_mode, presc_sel;
  logic        lock_prec, cp_gain, pwr_dn1, pwr_dn2, pd_polarity, ctr_reset, cfg_ready;
  logic [5:0]  a_count;
  logic [12:0] b_count;
  logic [2:0]  mux_sel;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_prog_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_div(ref_div), .bl_width(bl_width), .test_mode(test_mode), .lock_prec(lock_prec),
    .a_count(a_count), .b_count(b_count), .cp_gain(cp_gain), .presc_sel(presc_sel),
    .pwr_dn1(pwr_dn1), .pwr_dn2(pwr_dn2), .pd_polarity(pd_polarity), .mux_sel(mux_sel),
    .ctr_reset(ctr_reset), .cfg_ready(cfg_ready)
  );

  typedef struct {
    logic [48:0] v;
    string       tag;
  } item_t;
  item_t sb[$];

  // bench model of the shift word and latches
  logic [23:0] m_sr = '0, m_r = '0, m_n = '0, m_f = '0;
  logic [2:0]  m_seen = '0;

  function automatic logic [48:0] observed();
    return {ref_div, bl_width, test_mode, lock_prec, a_count, b_count, cp_gain,
            presc_sel, pwr_dn1, pwr_dn2, pd_polarity, mux_sel, ctr_reset, cfg_ready};
  endfunction

  function automatic logic [48:0] predict(logic [23:0] r, logic [23:0] n,
                                          logic [23:0] f, logic rdy);
    logic [13:0] rd; logic [5:0] a; logic [12:0] b;
    rd = 14'((r >> 2) & 24'h3FFF);
    a  = 6'((n >> 2) & 24'h3F);
    b  = 13'((n >> 8) & 24'h1FFF);
    return {rd, 2'((r >> 16) & 3), 2'((r >> 18) & 3), 1'((r >> 20) & 1),
            a, b, 1'((n >> 21) & 1),
            2'((f >> 22) & 3), 1'((f >> 3) & 1), 1'((f >> 21) & 1), 1'((f >> 7) & 1),
            3'((f >> 4) & 7), 1'((f >> 2) & 1), rdy};
  endfunction

  task automatic check(string tag, logic [48:0] act, logic [48:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends nbits of w MSB first, optional sclk toggles while load is high
  task automatic send(logic [23:0] w, int nbits, int junk, string tag);
    item_t it;
    ser_le = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
      m_sr = {m_sr[22:0], w[i]};
    end
    tick(4);
    ser_le = 1'b1;
    case (m_sr[1:0])
      2'b00: begin m_r = m_sr; m_seen[0] = 1'b1; end
      2'b01: begin m_n = m_sr; m_seen[1] = 1'b1; end
      default: begin m_f = m_sr; m_seen[2] = 1'b1; end
    endcase
    it.v = predict(m_r, m_n, m_f, &m_seen);
    it.tag = tag;
    sb.push_back(it);
    for (int j = 0; j < junk; j++) begin
      ser_data = 1'b1;
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
    tick(16);
    ser_le = 1'b0;
    tick(4);
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      wait (sb.size() != 0);
      tick(10);
      it = sb.pop_front();
      check(it.tag, observed(), it.v);
    end
  end

  always @(negedge clk) if (ctr_reset) pulses++;

  initial begin
    tick(4);
    check("R9 reset state", observed(), '0);
    rst_n = 1'b1;
    tick(4);
    check("R9 after reset", observed(), '0);

    send(24'h160640, 24, 0, "R3 reference write, R8 not ready");
    send(24'h20AA65, 24, 0, "R4 N write, R8 not ready");
    send(24'h8000B3, 24, 0, "R6 init copy to function, R8 ready");
    tick(2);
    total++;
    if (pulses != 1) begin
      bad++;
      $display("FAIL R6 pulse count actual=%0d expected=1", pulses);
    end
    send(24'hE0005A, 24, 0, "R5 function write, R2 others held");
    tick(2);
    total++;
    if (pulses != 1) begin
      bad++;
      $display("FAIL R6 plain function write pulsed actual=%0d expected=1", pulses);
    end
    send(24'h10011D, 24, 5, "R10 retune by N only");
    send(6'b100010, 6, 0, "R7 short word, R1 edges under high load ignored");
    send(24'h0003FD, 24, 0, "R2 N latch max A");

    rst_n = 1'b0;
    tick(4);
    check("R8 R9 mid-run reset", observed(), '0);
    rst_n = 1'b1;
    m_sr = '0; m_r = '0; m_n = '0; m_f = '0; m_seen = '0;
    tick(4);
    send(24'h0000A6, 24, 0, "R2 R8 function only after reset");
    send(24'h3FFFFC, 24, 0, "R3 reference all ones, R8 still not ready");
    tick(12);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule